// File: doc/BRIEF.md
# Eight-bit timer with shared prescaler

This block is an 8-bit up-counter that counts either the instruction-cycle clock or transitions on an external clock pin. A single prescaler sits in front of one of two consumers: the timer or the watchdog tick output. A control-register bit chooses the consumer, and a 3-bit rate field sets the division ratio. The rate field is decoded one power of two higher for the timer than for the watchdog.

The instruction cycle lasts four oscillator clocks. Two of its phase strobes, Q2 and Q4, enter the block. The internal source advances once per Q4. The external pin is sampled on Q2 and Q4 only, and the sample is compared with the previous one to find a single qualifying edge. Firmware loads the timer through a write port, which also clears the prescaler and briefly holds off counting. The overflow flag stays set until it is written.

Top module: `tick_timer8`

## Requirements
- R1: On reset the timer reads 0, the overflow flag reads 0 and every control bit is 1. The timer therefore counts falling pin edges without division, and the watchdog tick is divided 1:128.
- R2: The control word maps as follows: bit 5 is the source (1 selects the pin, 0 selects Q4), bit 4 is the edge (1 counts falling, 0 counts rising), bit 3 is the assignment (1 gives the prescaler to the watchdog, 0 gives it to the timer), and bits 2:0 hold the rate code. A write takes effect on the next clock.
- R3: With the internal source and the prescaler on the watchdog, the timer advances by exactly one per Q4 strobe. Apart from a load, the timer only ever holds its value or steps up by one.
- R4: With the prescaler on the timer, rate code n advances the timer once per 2^(n+1) source events.
- R5: With the prescaler on the watchdog, rate code n gives one wdt_tick_o per 2^n wdt_src_i pulses. With the prescaler on the timer, wdt_tick_o follows wdt_src_i one to one. wdt_tick_o is never high without wdt_src_i.
- R6: The pin is sampled only on clock edges where Q2 or Q4 is high. A level that the pin holds only across other edges is not counted. A level held for two or more clocks is always counted.
- R7: Each qualifying pin transition adds exactly one source event. Transitions of the other polarity add none.
- R8: A timer write loads the data on the next edge, clears the prescaler and discards the source events of the next two Q4 strobes. The timer does not change on the edge after the load.
- R9: A control write that changes the assignment bit clears the prescaler, so the first divided tick after the switch comes after a full period.
- R10: When the timer increments from 0xFF it wraps to 0x00 and sets the overflow flag. The flag holds until a flag write loads 0. If a wrap and a flag write fall on the same edge, the wrap wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ph_q2_i | input | 1 | Second-phase strobe of the instruction cycle |
| ph_q4_i | input | 1 | Fourth-phase strobe, which is the instruction clock |
| ext_clk_i | input | 1 | External count pin |
| wdt_src_i | input | 1 | Watchdog time-base pulse |
| ctrl_we_i | input | 1 | Control register write enable |
| ctrl_wdata_i | input | 6 | Control write data |
| tmr_we_i | input | 1 | Timer write enable |
| tmr_wdata_i | input | 8 | Timer load value |
| ovf_we_i | input | 1 | Overflow flag write enable |
| ovf_wdata_i | input | 1 | Overflow flag write value |
| tmr_o | output | 8 | Timer value |
| ovf_o | output | 1 | Sticky overflow flag |
| wdt_tick_o | output | 1 | Watchdog tick, divided or direct |

## Verification
The internal source is swept over all eight timer rate codes. Each run is long enough that the expected value is a known quotient, so an off-by-one power in the decode or a lost inhibit cycle shows up as a wrong count. Short loads check that the inhibit window is exactly two Q4 strobes. The pin is driven with pulses of several widths, with single-clock pulses placed on a sampling and a non-sampling phase, and with a half pulse under each edge polarity. These patterns separate correct phase sampling and edge choice from sampling on every clock or counting levels. The watchdog path is swept over every rate. One run leaves a known prescaler residue before the assignment is switched, which exposes a missing clear.

// File: rtl/tsp_pkg.sv
package tsp_pkg;
  localparam int RATE_W = 3;
  localparam int PSA_BIT = RATE_W;

  typedef struct packed {
    logic                src_ext;
    logic                edge_fall;
    logic                psa_wdt;
    logic [RATE_W-1:0]   rate;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/tsp_edge_sync.sv
module tsp_edge_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic smp_stb_i,
  input  logic lvl_i,
  output logic evt_o
);
  logic smp_q, vld_q;

  // one pulse per low-to-high change between consecutive phase samples
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_q <= 1'b0;
      vld_q <= 1'b0;
      evt_o <= 1'b0;
    end else begin
      evt_o <= smp_stb_i & vld_q & lvl_i & ~smp_q;
      if (smp_stb_i) begin
        smp_q <= lvl_i;
        vld_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/tsp_prescaler.sv
module tsp_prescaler #(
  parameter int PRE_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             evt_i,
  input  logic [PRE_W-1:0] mask_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] cnt_q;

  assign tick_o = evt_i && ((cnt_q & mask_i) == mask_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (evt_i) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/tsp_counter.sv
module tsp_counter #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  input  logic         inc_i,
  input  logic         flag_we_i,
  input  logic         flag_wdata_i,
  output logic [W-1:0] cnt_o,
  output logic         flag_o
);
  logic wrap;

  assign wrap = inc_i & ~ld_i & (cnt_o == {W{1'b1}});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_o <= '0;
    else if (ld_i)    cnt_o <= ld_val_i;
    else if (inc_i)   cnt_o <= cnt_o + 1'b1;
  end

  // wrap has priority over a software write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        flag_o <= 1'b0;
    else if (wrap)      flag_o <= 1'b1;
    else if (flag_we_i) flag_o <= flag_wdata_i;
  end
endmodule

// File: rtl/tick_timer8.sv
module tick_timer8
  import tsp_pkg::*;
#(
  parameter int TMR_W   = 8,
  parameter int PRE_W   = 8,
  parameter int INH_CYC = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ph_q2_i,
  input  logic              ph_q4_i,
  input  logic              ext_clk_i,
  input  logic              wdt_src_i,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  input  logic              tmr_we_i,
  input  logic [TMR_W-1:0]  tmr_wdata_i,
  input  logic              ovf_we_i,
  input  logic              ovf_wdata_i,
  output logic [TMR_W-1:0]  tmr_o,
  output logic              ovf_o,
  output logic              wdt_tick_o
);
  localparam int SH_W  = $clog2(PRE_W + 1);
  localparam int INH_W = (INH_CYC > 0) ? $clog2(INH_CYC + 1) : 1;

  ctrl_t            ctrl_q;
  logic             psa_sw;
  logic             ext_evt, src_evt, src_ok, inh_busy;
  logic [SH_W-1:0]  shamt;
  logic [PRE_W-1:0] pre_mask;
  logic             pre_evt, pre_clr, pre_tick, tmr_inc;

  assign psa_sw = ctrl_we_i && (ctrl_wdata_i[PSA_BIT] != ctrl_q.psa_wdt);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ctrl_q <= '1;
    else if (ctrl_we_i) ctrl_q <= ctrl_t'(ctrl_wdata_i);
  end

  // count hold-off after a timer load, measured in Q4 strobes
  generate
    if (INH_CYC > 0) begin : g_inh
      logic [INH_W-1:0] inh_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                   inh_q <= '0;
        else if (tmr_we_i)             inh_q <= INH_W'(INH_CYC);
        else if (ph_q4_i && inh_q != 0) inh_q <= inh_q - 1'b1;
      end
      assign inh_busy = (inh_q != 0);
    end else begin : g_no_inh
      assign inh_busy = 1'b0;
    end
  endgenerate

  tsp_edge_sync u_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .smp_stb_i (ph_q2_i | ph_q4_i),
    .lvl_i     (ext_clk_i ^ ctrl_q.edge_fall),
    .evt_o     (ext_evt)
  );

  assign src_evt = ctrl_q.src_ext ? ext_evt : ph_q4_i;
  assign src_ok  = src_evt & ~inh_busy;

  // timer path divides one power of two further than the watchdog path
  always_comb begin
    shamt    = SH_W'(ctrl_q.rate) + SH_W'(!ctrl_q.psa_wdt);
    pre_mask = ~({PRE_W{1'b1}} << shamt);
  end

  assign pre_evt = ctrl_q.psa_wdt ? wdt_src_i : src_ok;
  assign pre_clr = tmr_we_i | psa_sw;

  tsp_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (pre_clr),
    .evt_i  (pre_evt),
    .mask_i (pre_mask),
    .tick_o (pre_tick)
  );

  assign tmr_inc    = ctrl_q.psa_wdt ? src_ok : pre_tick;
  assign wdt_tick_o = ctrl_q.psa_wdt ? pre_tick : wdt_src_i;

  tsp_counter #(.W(TMR_W)) u_cnt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ld_i         (tmr_we_i),
    .ld_val_i     (tmr_wdata_i),
    .inc_i        (tmr_inc),
    .flag_we_i    (ovf_we_i),
    .flag_wdata_i (ovf_wdata_i),
    .cnt_o        (tmr_o),
    .flag_o       (ovf_o)
  );
endmodule

// File: rtl/tick_timer8_chk.sv
module tick_timer8_chk #(
  parameter int TMR_W   = 8,
  parameter int INH_CYC = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tmr_we_i,
  input logic [TMR_W-1:0] tmr_wdata_i,
  input logic             ovf_we_i,
  input logic             ovf_wdata_i,
  input logic             wdt_src_i,
  input logic [TMR_W-1:0] tmr_o,
  input logic             ovf_o,
  input logic             wdt_tick_o
);
  assert_load_value_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_we_i |=> tmr_o == $past(tmr_wdata_i));

  assert_unit_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tmr_we_i |=> (tmr_o == $past(tmr_o)) || (tmr_o == TMR_W'($past(tmr_o) + 1'b1)));

  assert_wrap_flags_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tmr_we_i && tmr_o == {TMR_W{1'b1}}) |=> (tmr_o != '0) || ovf_o);

  assert_flag_cause_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_o) |-> ($past(ovf_we_i) && $past(ovf_wdata_i)) ||
                     ($past(tmr_o) == {TMR_W{1'b1}} && tmr_o == '0));

  assert_wdt_gated_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_tick_o |-> wdt_src_i);

  generate
    if (INH_CYC > 0) begin : g_inh_chk
      assert_hold_after_load_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(tmr_we_i) && !tmr_we_i) |=> $stable(tmr_o));
    end
  endgenerate
endmodule

bind tick_timer8 tick_timer8_chk #(.TMR_W(TMR_W), .INH_CYC(INH_CYC)) u_chk (.*);

// File: tb/tick_timer8_tb_top.sv
module tick_timer8_tb_top;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] ph = 2'd0;
  logic       ext_clk = 1'b0, wdt_src = 1'b0;
  logic       ctrl_we = 1'b0, tmr_we = 1'b0, ovf_we = 1'b0, ovf_wd = 1'b0;
  logic [5:0] ctrl_wd = '0;
  logic [7:0] tmr_wd = '0;
  logic [7:0] tmr;
  logic       ovf, wdt_tick;
  int         n_run = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) ph <= ph + 2'd1;

  tick_timer8 dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .ph_q2_i(ph == 2'd1), .ph_q4_i(ph == 2'd3),
    .ext_clk_i(ext_clk), .wdt_src_i(wdt_src),
    .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wd),
    .tmr_we_i(tmr_we), .tmr_wdata_i(tmr_wd),
    .ovf_we_i(ovf_we), .ovf_wdata_i(ovf_wd),
    .tmr_o(tmr), .ovf_o(ovf), .wdt_tick_o(wdt_tick)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_ctrl(input logic [5:0] v);
    @(negedge clk); ctrl_we = 1'b1; ctrl_wd = v;
    @(negedge clk); ctrl_we = 1'b0;
  endtask

  task automatic wr_ovf(input logic v);
    @(negedge clk); ovf_we = 1'b1; ovf_wd = v;
    @(negedge clk); ovf_we = 1'b0;
  endtask

  // load lands on an edge whose phase is Q1
  task automatic wr_tmr_q1(input logic [7:0] v);
    @(negedge clk);
    while (ph != 2'd0) @(negedge clk);
    tmr_we = 1'b1; tmr_wd = v;
    @(negedge clk); tmr_we = 1'b0;
  endtask

  task automatic ext_pulses(input int n, input int hw, input int lw);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ext_clk = 1'b1;
      repeat (hw) @(negedge clk);
      ext_clk = 1'b0;
      repeat (lw - 1) @(negedge clk);
    end
    idle(8);
  endtask

  task automatic one_clk_pulse(input logic [1:0] at_ph);
    @(negedge clk);
    while (ph != at_ph) @(negedge clk);
    ext_clk = 1'b1;
    @(negedge clk); ext_clk = 1'b0;
    idle(4);
  endtask

  task automatic wdt_pulses(input int n, inout int ticks);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); wdt_src = 1'b1;
      #1 if (wdt_tick) ticks++;
      @(negedge clk); wdt_src = 1'b0;
    end
  endtask

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R1..: actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    int t;
    idle(4);
    @(negedge clk) rst_ni = 1'b1;
    chk("R1 timer after reset", tmr, 0);
    chk("R1 flag after reset", ovf, 0);

    // R1/R5: default watchdog rate 1:128
    t = 0; wdt_pulses(127, t);
    chk("R1 R5 default wdt 127 pulses", t, 0);
    wdt_pulses(1, t);
    chk("R1 R5 default wdt 128 pulses", t, 1);

    // R1/R7: default counts falling pin edges, undivided
    idle(8);
    @(negedge clk) ext_clk = 1'b1; idle(8);
    chk("R7 falling mode ignores rise", tmr, 0);
    @(negedge clk) ext_clk = 1'b0; idle(8);
    chk("R1 R7 falling mode counts fall", tmr, 1);
    ext_pulses(4, 2, 2);
    chk("R1 R6 min-width falls counted", tmr, 5);

    // R2/R7: rising edges, prescaler on watchdog
    wr_ctrl(6'b101000);
    wr_tmr_q1(8'h00); idle(12);
    @(negedge clk) ext_clk = 1'b1; idle(8);
    chk("R7 rising mode counts rise", tmr, 1);
    @(negedge clk) ext_clk = 1'b0; idle(8);
    chk("R7 rising mode ignores fall", tmr, 1);
    ext_pulses(3, 3, 5);
    ext_pulses(3, 2, 3);
    chk("R6 R7 mixed widths", tmr, 7);

    // R6: single-clock pulses on Q1 edges are never sampled
    for (int i = 0; i < 5; i++) one_clk_pulse(2'd0);
    chk("R6 pulse on non-sampling phase ignored", tmr, 7);
    one_clk_pulse(2'd1);
    chk("R6 pulse on Q2 counted", tmr, 8);

    // R4: external events through the prescaler
    wr_ctrl(6'b100001);
    wr_tmr_q1(8'h00); idle(12);
    ext_pulses(10, 2, 3);
    chk("R4 ext 1:4 of 10", tmr, 2);
    wr_ctrl(6'b100000);
    wr_tmr_q1(8'h00); idle(12);
    ext_pulses(7, 2, 2);
    chk("R4 ext 1:2 of 7", tmr, 3);

    // R4/R8: internal sweep over every timer rate code
    for (int r = 0; r < 8; r++) begin
      int ratio, k;
      ratio = 2 << r;
      k = 2 + 3 * ratio + r;
      wr_ctrl(6'(r));
      wr_tmr_q1(8'h10);
      idle(4 * k);
      chk($sformatf("R4 internal rate %0d", r), tmr, 8'h13);
    end

    // R8: load value and inhibit window
    wr_ctrl(6'b000000);
    wr_tmr_q1(8'h5A);
    chk("R8 load read back", tmr, 8'h5A);
    wr_tmr_q1(8'h40); idle(8);
    chk("R8 two Q4 strobes inhibited", tmr, 8'h40);
    wr_tmr_q1(8'h40); idle(12);
    chk("R8 third Q4 reaches prescaler", tmr, 8'h40);
    wr_tmr_q1(8'h40); idle(16);
    chk("R8 first count after inhibit", tmr, 8'h41);

    // R3: undivided internal clock
    wr_ctrl(6'b001000);
    wr_tmr_q1(8'h20); idle(48);
    chk("R3 one count per Q4", tmr, 8'h2A);

    // R10: wrap and sticky flag
    wr_ovf(1'b0);
    chk("R10 flag cleared", ovf, 0);
    wr_ctrl(6'b000000);
    wr_tmr_q1(8'hFE); idle(24);
    chk("R10 wrap to zero", tmr, 0);
    chk("R10 wrap sets flag", ovf, 1);
    idle(8);
    chk("R10 flag sticky", ovf, 1);
    wr_ovf(1'b0);
    chk("R10 write zero clears flag", ovf, 0);

    // R5: watchdog path sweep, prescaler cleared by the assignment switch
    for (int r = 0; r < 8; r++) begin
      int ratio, n;
      ratio = 1 << r;
      n = 2 * ratio + 1;
      wr_ctrl(6'(r));
      wr_ctrl(6'(8 + r));
      t = 0; wdt_pulses(n, t);
      chk($sformatf("R5 wdt rate %0d", r), t, n / ratio);
    end
    wr_ctrl(6'b000111);
    t = 0; wdt_pulses(5, t);
    chk("R5 wdt direct when prescaler on timer", t, 5);

    // R9: leave one count in the prescaler, then switch to watchdog
    @(negedge clk);
    while (ph != 2'd0) @(negedge clk);
    ctrl_we = 1'b1; ctrl_wd = 6'b000010;
    @(negedge clk); ctrl_we = 1'b0;
    idle(3);
    ctrl_we = 1'b1; ctrl_wd = 6'b001010;
    @(negedge clk); ctrl_we = 1'b0;
    t = 0; wdt_pulses(3, t);
    chk("R9 switch clears prescaler, no early tick", t, 0);
    wdt_pulses(1, t);
    chk("R9 full period after switch", t, 1);

    summary();
    $finish;
  end
endmodule